// File: doc/BRIEF.md
# Flash Write Command Sequencer

This block sits between a register bus and an embedded flash array. Software writes command strobes, one bit per action. The block turns each accepted command into a program or erase operation. It hands that operation to the flash macro over a simple start/done handshake, together with an operation code, an address and data.

The block keeps its own word address. Software loads this address from a base-address input, and the block advances it after every program operation. When an advance would cross a page boundary, the address wraps back to the start of the same page.

Programming works in two ways:
- A write-once command programs the single buffered word.
- A streaming session programs each word (or each pair of words, in double-word mode) as soon as the data buffer fills. The session ends on an explicit end command, or when no data arrives within a fixed number of cycles.

Page erase and mass erase are also supported, and an erase can be aborted. A clear command empties the data buffer and raises a data request.

Top module: `flash_wcmd_seq`

## Requirements
- R1: Commands act only in a cycle where `cmd_stb` is high. Each bit of `cmd_bits` is one action: bit 0 load address, bit 1 page erase, bit 2 write once, bit 3 start stream, bit 4 end stream, bit 5 abort erase, bit 6 mass erase, bit 7 clear data. A 0 bit does nothing. From idle, only the first set bit in the order load, mass erase, page erase, write once, start stream is considered. After reset the block is idle, with `cur_addr` = 0, `wdata_ready` = 1 and `dma_req` = 0.
- R2: Load address sets `cur_addr` to `base_addr` with bits 1:0 cleared, one cycle after the strobe.
- R3: When a single-word program finishes (`fl_done` while `fl_op` = 1), `cur_addr` advances by 4.
- R4: An advance changes only the in-page offset (the low log2(PAGE_BYTES) bits), modulo the page size. The page number is kept.
- R5: Write once is accepted only while `wren` = 1. It pulses `fl_start` for one cycle with `fl_op` = 1, `fl_addr` = `cur_addr`, `fl_data[31:0]` = the first buffered word and `fl_dword` = 0. Without `wren` the command is ignored.
- R6: Page erase is accepted only while `wren` = 1. It issues `fl_op` = 2 with `fl_addr` set to the base of the current page.
- R7: Mass erase is accepted only while `mass_unlock` = 1. It issues `fl_op` = 3 with `fl_addr` = 0.
- R8: Start stream raises `stream_active`. Each time the buffer holds the required words, a program is issued. After its `fl_done`, the block waits for more data, and `fl_start` never stays high for two cycles in a row.
- R9: While streaming and waiting, if no data write arrives for TMO_CYC (= CLK_MHZ*TMO_US) consecutive cycles, `stream_active` falls.
- R10: End stream lowers `stream_active` on the next cycle. If a program is in flight, the block returns to idle after its `fl_done`.
- R11: In double-word mode, streaming waits for two words. It programs `fl_data` = {second, first} with `fl_dword` = 1, and `cur_addr` advances by 8.
- R12: Abort, during an erase, drops `busy` on the next cycle and pulses `fl_abort` once. During a program it is ignored.
- R13: Clear data empties the buffer, taking priority over a same-cycle data write. It sets `wdata_ready` and `dma_req`. `dma_req` is also set when a streamed program finishes, and is cleared by a data write.
- R14: `busy` is high from the cycle `fl_start` pulses until `fl_done` (or abort). While not idle, load, erase and write commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command strobe |
| cmd_bits | input | 8 | Command bits, one per action |
| base_addr | input | AW | Base address register value |
| wren | input | 1 | Write/erase enable control |
| dword_mode | input | 1 | Double-word streaming mode |
| mass_unlock | input | 1 | Mass erase lock is open |
| wdata_we | input | 1 | Write-data register written |
| wdata | input | 32 | Write-data value |
| fl_done | input | 1 | Flash operation finished |
| fl_start | output | 1 | Flash operation start pulse |
| fl_abort | output | 1 | Flash erase abort pulse |
| fl_op | output | 2 | Operation: 0 none, 1 program, 2 page erase, 3 mass erase |
| fl_dword | output | 1 | Program carries two words |
| fl_addr | output | AW | Operation address |
| fl_data | output | 64 | Program data, second word high |
| busy | output | 1 | Flash operation in flight |
| stream_active | output | 1 | Streaming session open |
| wdata_ready | output | 1 | Buffer can take a word |
| dma_req | output | 1 | Data request |
| cur_addr | output | AW | Internal word address |

## Verification
The assertions assume the flash macro raises `fl_done` only for an operation in flight. They also assume `dword_mode` is changed only while the data buffer is empty and no stream is open, since the buffer-full rule depends on it. The stimulus follows both rules: the responder pulses `fl_done` a fixed number of cycles after `fl_start` and cancels on `fl_abort`, and the mode is switched only between sessions, with the buffer drained. Data is written only while the buffer reports ready, except where the clear-priority case is exercised on purpose.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        FOP_NONE = 2'd0,
        FOP_PROG = 2'd1,
        FOP_PAGE = 2'd2,
        FOP_MASS = 2'd3
    } fop_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_PROG = 2'd2
    } sq_e;

    localparam int CMD_W = 8;

    typedef struct packed {
        logic load;
        logic pger;
        logic once;
        logic trig;
        logic fin;
        logic abort;
        logic mass;
        logic clr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic stb, input logic [CMD_W-1:0] b);
        cmd_t c;
        logic [CMD_W-1:0] g;
        g       = stb ? b : '0;
        c.load  = g[0];
        c.pger  = g[1];
        c.once  = g[2];
        c.trig  = g[3];
        c.fin   = g[4];
        c.abort = g[5];
        c.mass  = g[6];
        c.clr   = g[7];
        return c;
    endfunction

endpackage

// File: rtl/fwc_addr_unit.sv
module fwc_addr_unit #(
    parameter int AW      = 24,
    parameter int PG_BITS = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          step8,
    output logic [AW-1:0] addr
);
    logic [PG_BITS-1:0] off_nxt;

    always_comb begin
        off_nxt = addr[PG_BITS-1:0] + (step8 ? PG_BITS'(8) : PG_BITS'(4));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val & ~AW'(3);
        end else if (adv) begin
            addr <= {addr[AW-1:PG_BITS], off_nxt};
        end
    end

    // R4: an advance never changes the page number
    a_r4_page_kept: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (addr[AW-1:PG_BITS] == $past(addr[AW-1:PG_BITS])));

    // R2: a load leaves a word-aligned address
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr[1:0] == 2'b00));

endmodule

// File: rtl/fwc_wbuf.sv
module fwc_wbuf #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          clr,
    input  logic          consume,
    input  logic          dword,
    output logic          ready,
    output logic          full,
    output logic [DW-1:0] word0,
    output logic [DW-1:0] word1
);
    logic [1:0] cnt;
    logic [1:0] need;
    logic       acc;

    always_comb begin
        need  = dword ? 2'd2 : 2'd1;
        ready = (cnt < need);
        full  = (cnt >= need);
        acc   = we && ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            word0 <= '0;
            word1 <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (consume) begin
            cnt <= acc ? 2'd1 : 2'd0;
            if (acc) word0 <= wdata;
        end else if (acc) begin
            if (cnt == 2'd0) word0 <= wdata;
            else             word1 <= wdata;
            cnt <= cnt + 2'd1;
        end
    end

    // R13: the buffer never holds more than two words
    a_r13_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= 2'd2);

    // R13: a clear leaves the buffer able to take data
    a_r13_clr_ready: assert property (@(posedge clk) disable iff (rst)
        (clr && $stable(dword)) |=> ready);

endmodule

// File: rtl/fwc_tmo.sv
module fwc_tmo #(
    parameter int TMO_CYC = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt;

    always_comb begin
        expired = run && !kick && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + TW'(1);
        end
    end

    // R9: the idle count stays inside the window
    a_r9_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/flash_wcmd_seq.sv
module flash_wcmd_seq #(
    parameter int AW         = 24,
    parameter int PAGE_BYTES = 4096,
    parameter int CLK_MHZ    = 4,
    parameter int TMO_US     = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_stb,
    input  logic [7:0]    cmd_bits,
    input  logic [AW-1:0] base_addr,
    input  logic          wren,
    input  logic          dword_mode,
    input  logic          mass_unlock,
    input  logic          wdata_we,
    input  logic [31:0]   wdata,
    input  logic          fl_done,
    output logic          fl_start,
    output logic          fl_abort,
    output logic [1:0]    fl_op,
    output logic          fl_dword,
    output logic [AW-1:0] fl_addr,
    output logic [63:0]   fl_data,
    output logic          busy,
    output logic          stream_active,
    output logic          wdata_ready,
    output logic          dma_req,
    output logic [AW-1:0] cur_addr
);
    import fwc_pkg::*;

    localparam int PG_BITS = $clog2(PAGE_BYTES);
    localparam int TMO_CYC = CLK_MHZ * TMO_US;

    sq_e   st_q;
    fop_e  op_q;
    logic  strm_q;
    cmd_t  c;

    logic  buf_full, buf_ready, buf_consume;
    logic [31:0] w0, w1;
    logic  tmo_exp;

    logic  is_idle, is_wait, is_prog;
    logic  pick_mass, pick_page, pick_once, pick_trig;
    logic  go_mass, go_page, go_once, go_trig, go_strm;
    logic  wt_end, tmo_out, do_abort, done_ok, strm_done, launch, addr_adv;

    always_comb begin
        c         = decode_cmd(cmd_stb, cmd_bits);
        is_idle   = (st_q == SQ_IDLE);
        is_wait   = (st_q == SQ_WAIT);
        is_prog   = (st_q == SQ_PROG);

        pick_mass = is_idle && !c.load && c.mass;
        pick_page = is_idle && !c.load && !c.mass && c.pger;
        pick_once = is_idle && !c.load && !c.mass && !c.pger && c.once;
        pick_trig = is_idle && !c.load && !c.mass && !c.pger && !c.once && c.trig;

        go_mass   = pick_mass && mass_unlock;
        go_page   = pick_page && wren;
        go_once   = pick_once && wren;
        go_trig   = pick_trig;

        wt_end    = is_wait && c.fin;
        go_strm   = is_wait && !c.fin && buf_full;
        tmo_out   = is_wait && !c.fin && !buf_full && tmo_exp;

        do_abort  = is_prog && c.abort && (op_q != FOP_PROG);
        done_ok   = is_prog && !do_abort && fl_done;
        strm_done = done_ok && (op_q == FOP_PROG) && strm_q && !c.fin;
        addr_adv  = done_ok && (op_q == FOP_PROG);

        buf_consume = go_once || go_strm;
        launch      = go_mass || go_page || go_once || go_strm;
    end

    fwc_addr_unit #(.AW(AW), .PG_BITS(PG_BITS)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (is_idle && c.load),
        .load_val (base_addr),
        .adv      (addr_adv),
        .step8    (fl_dword),
        .addr     (cur_addr)
    );

    fwc_wbuf #(.DW(32)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .we      (wdata_we),
        .wdata   (wdata),
        .clr     (c.clr),
        .consume (buf_consume),
        .dword   (dword_mode),
        .ready   (buf_ready),
        .full    (buf_full),
        .word0   (w0),
        .word1   (w1)
    );

    fwc_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (is_wait),
        .kick    (wdata_we),
        .expired (tmo_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            op_q     <= FOP_NONE;
            strm_q   <= 1'b0;
            fl_start <= 1'b0;
            fl_abort <= 1'b0;
            fl_addr  <= '0;
            fl_data  <= '0;
            fl_dword <= 1'b0;
        end else begin
            fl_start <= launch;
            fl_abort <= do_abort;
            if (go_mass) begin
                op_q    <= FOP_MASS;
                fl_addr <= '0;
                st_q    <= SQ_PROG;
            end
            if (go_page) begin
                op_q    <= FOP_PAGE;
                fl_addr <= {cur_addr[AW-1:PG_BITS], {PG_BITS{1'b0}}};
                st_q    <= SQ_PROG;
            end
            if (go_once) begin
                op_q     <= FOP_PROG;
                fl_addr  <= cur_addr;
                fl_data  <= {32'h0, w0};
                fl_dword <= 1'b0;
                strm_q   <= 1'b0;
                st_q     <= SQ_PROG;
            end
            if (go_trig) begin
                st_q   <= SQ_WAIT;
                strm_q <= 1'b1;
            end
            if (wt_end || tmo_out) begin
                st_q   <= SQ_IDLE;
                strm_q <= 1'b0;
            end
            if (go_strm) begin
                op_q     <= FOP_PROG;
                fl_addr  <= cur_addr;
                fl_data  <= dword_mode ? {w1, w0} : {32'h0, w0};
                fl_dword <= dword_mode;
                st_q     <= SQ_PROG;
            end
            if (is_prog) begin
                if (c.fin) strm_q <= 1'b0;
                if (do_abort) begin
                    st_q   <= SQ_IDLE;
                    op_q   <= FOP_NONE;
                    strm_q <= 1'b0;
                end else if (fl_done) begin
                    op_q <= FOP_NONE;
                    st_q <= strm_done ? SQ_WAIT : SQ_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   dma_req <= 1'b0;
        else if (c.clr || strm_done) dma_req <= 1'b1;
        else if (wdata_we)         dma_req <= 1'b0;
    end

    always_comb begin
        fl_op         = op_q;
        busy          = is_prog;
        stream_active = strm_q;
        wdata_ready   = buf_ready;
    end

    // R8: the start strobe is a single-cycle pulse
    a_r8_start_pulse: assert property (@(posedge clk) disable iff (rst)
        fl_start |=> !fl_start);

    // R14: busy only rises together with a start pulse
    a_r14_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> fl_start);

    // R5: write once without enable leaves the block idle
    a_r5_once_gated: assert property (@(posedge clk) disable iff (rst)
        (!busy && !stream_active && cmd_stb && cmd_bits == 8'h04 && !wren) |=> !busy);

    // R7: locked mass erase leaves the block idle
    a_r7_mass_gated: assert property (@(posedge clk) disable iff (rst)
        (!busy && !stream_active && cmd_stb && cmd_bits == 8'h40 && !mass_unlock) |=> !busy);

    // R12: abort of an erase ends it at once with one abort pulse
    a_r12_abort: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_stb && cmd_bits[5] && fl_op != 2'd1) |=> (!busy && fl_abort));

    // R10: end stream closes the session on the next cycle
    a_r10_end: assert property (@(posedge clk) disable iff (rst)
        (stream_active && cmd_stb && cmd_bits[4]) |=> !stream_active);

endmodule

// File: tb/sim_flash_wcmd_seq.sv
module sim_flash_wcmd_seq;
    localparam int CLK_P = 10;
    localparam int TMO   = 120;
    localparam int AW    = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_stb = 1'b0;
    logic [7:0] cmd_bits = 8'h0;
    logic [AW-1:0] base_addr = '0;
    logic wren = 1'b0, dword_mode = 1'b0, mass_unlock = 1'b0;
    logic wdata_we = 1'b0;
    logic [31:0] wdata = '0;
    logic fl_done = 1'b0;
    logic fl_start, fl_abort, fl_dword, busy, stream_active, wdata_ready, dma_req;
    logic [1:0] fl_op;
    logic [AW-1:0] fl_addr, cur_addr;
    logic [63:0] fl_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_wcmd_seq #(.AW(AW), .PAGE_BYTES(4096), .CLK_MHZ(4), .TMO_US(30)) u0 (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_bits(cmd_bits),
        .base_addr(base_addr), .wren(wren), .dword_mode(dword_mode),
        .mass_unlock(mass_unlock), .wdata_we(wdata_we), .wdata(wdata),
        .fl_done(fl_done), .fl_start(fl_start), .fl_abort(fl_abort),
        .fl_op(fl_op), .fl_dword(fl_dword), .fl_addr(fl_addr), .fl_data(fl_data),
        .busy(busy), .stream_active(stream_active), .wdata_ready(wdata_ready),
        .dma_req(dma_req), .cur_addr(cur_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [AW-1:0] m_addr;
    int            m_st;
    bit            m_strm, m_start, m_abort, m_fdw, m_dma;
    int            m_tmo, m_op;
    logic [AW-1:0] m_faddr;
    logic [63:0]   m_fdata;
    logic [31:0]   m_q[$];
    logic [31:0]   m_s0;

    always @(posedge clk) begin
        if (rst) begin
            m_addr = '0; m_st = 0; m_strm = 0; m_start = 0; m_abort = 0;
            m_fdw = 0; m_dma = 0; m_tmo = 0; m_op = 0; m_faddr = '0;
            m_fdata = '0; m_q.delete(); m_s0 = '0;
        end else begin
            logic [7:0] c;
            int need;
            bit full, acc, cons, sdone;
            c = cmd_stb ? cmd_bits : 8'h0;
            need = dword_mode ? 2 : 1;
            full = (m_q.size() >= need);
            acc  = wdata_we && (m_q.size() < need);
            cons = 0; sdone = 0; m_start = 0; m_abort = 0;
            case (m_st)
                0: begin
                    if (c[0]) m_addr = base_addr & ~24'h3;
                    else if (c[6]) begin
                        if (mass_unlock) begin m_op = 3; m_faddr = '0; m_st = 2; m_start = 1; end
                    end else if (c[1]) begin
                        if (wren) begin m_op = 2; m_faddr = m_addr & ~24'hFFF; m_st = 2; m_start = 1; end
                    end else if (c[2]) begin
                        if (wren) begin
                            m_op = 1; m_faddr = m_addr;
                            m_fdata = {32'h0, (m_q.size() > 0) ? m_q[0] : m_s0};
                            m_fdw = 0; m_strm = 0; m_st = 2; m_start = 1; cons = 1;
                        end
                    end else if (c[3]) begin
                        m_st = 1; m_strm = 1; m_tmo = 0;
                    end
                end
                1: begin
                    if (c[4]) begin m_st = 0; m_strm = 0; end
                    else if (full) begin
                        m_op = 1; m_faddr = m_addr;
                        m_fdata = dword_mode ? {m_q[1], m_q[0]} : {32'h0, m_q[0]};
                        m_fdw = dword_mode; m_st = 2; m_start = 1; cons = 1;
                    end else if (wdata_we) m_tmo = 0;
                    else if (m_tmo == TMO - 1) begin m_st = 0; m_strm = 0; end
                    else m_tmo++;
                end
                default: begin
                    if (c[5] && m_op != 1) begin
                        m_st = 0; m_op = 0; m_strm = 0; m_abort = 1;
                    end else if (fl_done) begin
                        if (m_op == 1) begin
                            logic [AW-1:0] off;
                            off = (m_addr + (m_fdw ? 8 : 4)) & 24'hFFF;
                            m_addr = (m_addr & ~24'hFFF) | off;
                        end
                        if (m_op == 1 && m_strm && !c[4]) begin
                            m_st = 1; m_tmo = 0; sdone = 1;
                        end else m_st = 0;
                        m_op = 0;
                    end
                    if (c[4]) m_strm = 0;
                end
            endcase
            if (c[7]) m_q.delete();
            else begin
                if (cons) m_q.delete();
                if (acc) begin
                    if (m_q.size() == 0) m_s0 = wdata;
                    m_q.push_back(wdata);
                end
            end
            if (c[7] || sdone) m_dma = 1;
            else if (wdata_we) m_dma = 0;
        end
    end

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk("R14", "busy", 64'(busy), 64'(m_st == 2));
            chk("R8", "fl_start", 64'(fl_start), 64'(m_start));
            chk("R12", "fl_abort", 64'(fl_abort), 64'(m_abort));
            chk("R6", "fl_op", 64'(fl_op), 64'(m_op));
            chk("R3", "cur_addr", 64'(cur_addr), 64'(m_addr));
            chk("R13", "wdata_ready", 64'(wdata_ready), 64'(m_q.size() < (dword_mode ? 2 : 1)));
            chk("R13", "dma_req", 64'(dma_req), 64'(m_dma));
            chk("R9", "stream_active", 64'(stream_active), 64'(m_strm));
            if (fl_start) begin
                chk("R4", "fl_addr", 64'(fl_addr), 64'(m_faddr));
                if (m_op == 1) begin
                    chk("R11", "fl_data", fl_data, m_fdata);
                    chk("R11", "fl_dword", 64'(fl_dword), 64'(m_fdw));
                end
            end
        end
    end

    // flash responder
    int rcnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            fl_done = 1'b0;
            if (fl_abort) rcnt = 0;
            else if (fl_start) rcnt = 3;
            else if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) fl_done = 1'b1;
            end
        end
    end

    task automatic cmd(input logic [7:0] b);
        @(negedge clk); cmd_stb = 1'b1; cmd_bits = b;
        @(negedge clk); cmd_stb = 1'b0; cmd_bits = 8'h0;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wdata_we = 1'b1; wdata = d;
        @(negedge clk); wdata_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        idle(2);
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [AW-1:0] a0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset busy", 64'(busy), 64'd0);
        chk("R1", "reset cur_addr", 64'(cur_addr), 64'd0);
        chk("R1", "reset wdata_ready", 64'(wdata_ready), 64'd1);
        chk("R1", "reset dma_req", 64'(dma_req), 64'd0);

        base_addr = 24'h012FF7;
        cmd(8'h01);
        chk("R2", "loaded address", 64'(cur_addr), 64'h012FF4);

        cmd(8'h04);
        chk("R5", "write once without enable ignored", 64'(busy), 64'd0);

        wren = 1'b1;
        push(32'hA1A1_0001);
        cmd(8'h04);
        chk("R5", "write once starts", 64'(busy), 64'd1);
        chk("R5", "write once data", fl_data, 64'hA1A1_0001);
        wait_done();
        chk("R3", "advance by 4", 64'(cur_addr), 64'h012FF8);
        push(32'hA1A1_0002); cmd(8'h04); wait_done();
        push(32'hA1A1_0003); cmd(8'h04); wait_done();
        chk("R4", "wrap to page base", 64'(cur_addr), 64'h012000);

        cmd(8'h02);
        chk("R6", "page erase op", 64'(fl_op), 64'd2);
        chk("R6", "page erase address", 64'(fl_addr), 64'h012000);
        base_addr = 24'h000100;
        cmd(8'h01);
        wait_done();
        chk("R14", "load while busy ignored", 64'(cur_addr), 64'h012000);

        wren = 1'b0;
        cmd(8'h02);
        chk("R6", "page erase without enable ignored", 64'(busy), 64'd0);
        wren = 1'b1;

        cmd(8'h40);
        chk("R7", "locked mass erase ignored", 64'(busy), 64'd0);
        mass_unlock = 1'b1;
        cmd(8'h40);
        chk("R7", "mass erase op", 64'(fl_op), 64'd3);
        cmd(8'h20);
        chk("R12", "abort ends erase", 64'(busy), 64'd0);
        idle(6);
        mass_unlock = 1'b0;

        push(32'hB0B0_0000);
        cmd(8'h04);
        cmd(8'h20);
        chk("R12", "abort during program ignored", 64'(busy), 64'd1);
        wait_done();

        cmd(8'h08);
        chk("R8", "stream opens", 64'(stream_active), 64'd1);
        push(32'hC0C0_0001); idle(5); wait_done();
        push(32'hC0C0_0002); idle(3); wait_done();
        chk("R13", "dma after streamed word", 64'(dma_req), 64'd1);
        push(32'hC0C0_0003); wait_done();
        cmd(8'h10);
        chk("R10", "end closes stream", 64'(stream_active), 64'd0);

        cmd(8'h08);
        idle(TMO - 10);
        chk("R9", "stream still open before timeout", 64'(stream_active), 64'd1);
        idle(15);
        chk("R9", "stream closed by timeout", 64'(stream_active), 64'd0);

        dword_mode = 1'b1;
        a0 = cur_addr;
        cmd(8'h08);
        push(32'hD0D0_0001);
        chk("R11", "one word not enough", 64'(busy), 64'd0);
        push(32'hD0D0_0002);
        wait_done();
        chk("R11", "advance by 8", 64'(cur_addr), 64'(a0 + 24'd8));
        cmd(8'h10);
        dword_mode = 1'b0;

        cmd(8'h08);
        push(32'hE0E0_0001);
        idle(1);
        cmd(8'h10);
        wait_done();
        chk("R10", "end during program returns idle", 64'(stream_active), 64'd0);

        push(32'hF0F0_0001);
        chk("R13", "buffer full not ready", 64'(wdata_ready), 64'd0);
        cmd(8'h80);
        chk("R13", "clear sets ready", 64'(wdata_ready), 64'd1);
        chk("R13", "clear sets dma", 64'(dma_req), 64'd1);

        a0 = cur_addr;
        base_addr = 24'h000333;
        @(negedge clk); cmd_stb = 1'b0; cmd_bits = 8'h01;
        @(negedge clk); cmd_bits = 8'h00;
        chk("R1", "bits without strobe ignored", 64'(cur_addr), 64'(a0));

        idle(4);
        summary();
    end
endmodule